// File: doc/BRIEF.md
# Sixteen-Source Priority Interrupt Controller

This block collects sixteen level-sensitive interrupt requests into one processor interrupt line. Eight requests come from on-chip peripherals and eight from external pins. The two groups are merged into a single pending word in which they alternate, so the whole set shares one fixed priority order. A per-source enable mask selects which pending requests may reach the processor. The single interrupt output is raised whenever any enabled request is pending.

Along with the interrupt line, the block presents a vector byte for the most urgent source that is both pending and enabled. The byte is a word-aligned offset: software adds it to the base address of a handler jump table and branches to the result. When nothing enabled is pending, the byte reads as a reserved no-interrupt code. A small register bus lets software read the pending word, read and write the mask, and read the vector. A request is removed only by clearing it at its source.

Top module: `irq_prio_ctrl`

## Requirements
- R1: Pending bit 2k holds external request k and pending bit 2k+1 holds internal request k, for k = 0..7, so the two groups alternate in one word.
- R2: Each pending bit follows the level of its request line, one clock edge after the line changes. A bus write to the pending address (address 0) has no effect on the pending word.
- R3: During and after reset the mask is 0x0000, the interrupt output is low and the vector is 0xFF.
- R4: A bus write to address 1 loads all sixteen mask bits from write data bits 15:0. The new mask reads back from address 1 right after the write edge.
- R5: The interrupt output is the OR of (pending AND mask), registered. It changes one edge after the pending word or the mask changes.
- R6: When any enabled request is pending, the vector is 4 times the lowest pending-and-enabled bit index, so bit 0 has the highest priority (0x00) and bit 15 the lowest (0x3C). It is registered with the same timing as the interrupt output.
- R7: When no enabled request is pending, the vector is 0xFF and the interrupt output is low, whatever the disabled requests are doing.
- R8: A bus read of address 2 returns the current vector in bits 7:0, with bits 15:8 zero. A bus read of address 0 returns the pending word.
- R9: Address 3 reads as zero and ignores writes. With the select input low, read data is zero and no register changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_req | input | 8 | Level request lines from external pins |
| int_req | input | 8 | Level request lines from internal peripherals |
| bus_sel | input | 1 | Register bus select |
| bus_wr | input | 1 | Register bus write strobe (with select) |
| bus_addr | input | 2 | Register address: 0 pending, 1 mask, 2 vector, 3 reserved |
| bus_wdata | input | 16 | Register bus write data |
| bus_rdata | output | 16 | Register bus read data (combinational from registers) |
| irq_out | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Vector byte of the most urgent enabled pending source |

## Verification
A request change shows up in the pending word one edge after it is applied, and in the interrupt output and vector one edge after that. A mask write moves the mask on its own edge and the interrupt output and vector one edge later. The bench drives its inputs 1 ns after a rising edge and counts edges to match these latencies. It samples each result 1 ns after the edge on which that result is due. It also checks the intermediate cycle, in which the pending word has moved but the interrupt output has not yet.

// File: rtl/irq_ctrl_pkg.sv
// Shared definitions for the priority interrupt controller.
// Assumes a two-bit register address space on the bus.
package irq_ctrl_pkg;

    // Register bus address decode
    typedef enum logic [1:0] {
        REG_PEND = 2'd0,
        REG_MASK = 2'd1,
        REG_VEC  = 2'd2,
        REG_RSVD = 2'd3
    } irq_reg_e;

endpackage

// File: rtl/irq_src_merge.sv
// Interleaves two groups of level requests into one pending word and
// registers it. Assumes the request lines are already synchronous to clk.
module irq_src_merge #(
    parameter int N_PER_GROUP = 8,
    localparam int NUM_SRC    = 2 * N_PER_GROUP
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_PER_GROUP-1:0] ext_req,
    input  logic [N_PER_GROUP-1:0] int_req,
    output logic [NUM_SRC-1:0]     pend_q
);

    logic [NUM_SRC-1:0] woven;

    // R1: even bits carry external lines, odd bits internal lines
    for (genvar k = 0; k < N_PER_GROUP; k++) begin : g_weave
        assign woven[2*k]   = ext_req[k];
        assign woven[2*k+1] = int_req[k];
    end

    // R2: pending word tracks request levels, no software clear path
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= woven;
    end

endmodule

// File: rtl/irq_mask_reg.sv
// Holds the per-source enable mask, loaded from the register bus.
// Assumes write enable is already decoded for the mask address.
module irq_mask_reg #(
    parameter int NUM_SRC = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [NUM_SRC-1:0] wdata,
    output logic [NUM_SRC-1:0] mask_q
);

    // R3/R4: clear on reset, load on decoded write
    always_ff @(posedge clk) begin
        if (!rst_n)     mask_q <= '0;
        else if (wr_en) mask_q <= wdata;
    end

endmodule

// File: rtl/irq_prio_vec.sv
// Picks the lowest-index enabled pending source and registers the
// interrupt line and its table-offset vector. Assumes the no-interrupt
// code lies beyond the largest legal offset.
module irq_prio_vec #(
    parameter int          NUM_SRC     = 16,
    parameter int          VEC_W       = 8,
    parameter int          ENTRY_BYTES = 4,
    parameter logic [VEC_W-1:0] NONE_CODE = 8'hFF,
    localparam int         IDX_W       = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] pend,
    input  logic [NUM_SRC-1:0] mask,
    output logic               irq_q,
    output logic [VEC_W-1:0]   vec_q
);

    logic [NUM_SRC-1:0] active;
    logic [IDX_W-1:0]   win_idx;
    logic               any_act;
    logic [VEC_W-1:0]   vec_next;

    assign active  = pend & mask;
    assign any_act = |active;

    // Lowest set index wins: scan downward so the last hit is the lowest
    always_comb begin
        win_idx = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (active[i]) win_idx = IDX_W'(i);
        end
    end

    // Vector is the word offset of the winner, or the reserved code
    always_comb begin
        if (any_act) vec_next = VEC_W'(win_idx) * VEC_W'(ENTRY_BYTES);
        else         vec_next = NONE_CODE;
    end

    // R5/R6/R7: register the processor-facing outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
            vec_q <= NONE_CODE;
        end else begin
            irq_q <= any_act;
            vec_q <= vec_next;
        end
    end

endmodule

// File: rtl/irq_prio_ctrl.sv
// Top of the priority interrupt controller: request merge, mask
// register, priority vector and register bus decode.
// Assumes single-cycle bus accesses and read data sampled combinationally.
module irq_prio_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int N_PER_GROUP = 8,
    parameter int VEC_W       = 8,
    parameter int ENTRY_BYTES = 4,
    parameter logic [VEC_W-1:0] NONE_CODE = 8'hFF,
    localparam int NUM_SRC    = 2 * N_PER_GROUP
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_PER_GROUP-1:0] ext_req,
    input  logic [N_PER_GROUP-1:0] int_req,
    input  logic                   bus_sel,
    input  logic                   bus_wr,
    input  logic [1:0]             bus_addr,
    input  logic [NUM_SRC-1:0]     bus_wdata,
    output logic [NUM_SRC-1:0]     bus_rdata,
    output logic                   irq_out,
    output logic [VEC_W-1:0]       vec_out
);

    logic [NUM_SRC-1:0] pend_vec;
    logic [NUM_SRC-1:0] mask_vec;
    logic               mask_wr;
    irq_reg_e           reg_sel;

    assign reg_sel = irq_reg_e'(bus_addr);
    assign mask_wr = bus_sel && bus_wr && (reg_sel == REG_MASK);

    irq_src_merge #(.N_PER_GROUP(N_PER_GROUP)) u_merge (
        .clk     (clk),
        .rst_n   (rst_n),
        .ext_req (ext_req),
        .int_req (int_req),
        .pend_q  (pend_vec)
    );

    irq_mask_reg #(.NUM_SRC(NUM_SRC)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (mask_wr),
        .wdata  (bus_wdata),
        .mask_q (mask_vec)
    );

    irq_prio_vec #(
        .NUM_SRC     (NUM_SRC),
        .VEC_W       (VEC_W),
        .ENTRY_BYTES (ENTRY_BYTES),
        .NONE_CODE   (NONE_CODE)
    ) u_prio (
        .clk   (clk),
        .rst_n (rst_n),
        .pend  (pend_vec),
        .mask  (mask_vec),
        .irq_q (irq_out),
        .vec_q (vec_out)
    );

    // R8/R9: read mux, zero when unselected or reserved
    always_comb begin
        bus_rdata = '0;
        if (bus_sel) begin
            case (reg_sel)
                REG_PEND: bus_rdata = pend_vec;
                REG_MASK: bus_rdata = mask_vec;
                REG_VEC:  bus_rdata = NUM_SRC'(vec_out);
                default:  bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/irq_ctrl_checker.sv
// Property checker for the priority interrupt controller, bound to the top.
// Assumes synchronous active-low reset held from time zero.
module irq_ctrl_checker #(
    parameter int N_PER_GROUP = 8,
    parameter int VEC_W       = 8,
    parameter int ENTRY_BYTES = 4,
    parameter logic [VEC_W-1:0] NONE_CODE = 8'hFF,
    localparam int NUM_SRC    = 2 * N_PER_GROUP,
    localparam int IDX_W      = $clog2(NUM_SRC),
    localparam int SHIFT      = $clog2(ENTRY_BYTES)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [N_PER_GROUP-1:0] ext_req,
    input logic [N_PER_GROUP-1:0] int_req,
    input logic                   bus_sel,
    input logic                   bus_wr,
    input logic [1:0]             bus_addr,
    input logic [NUM_SRC-1:0]     bus_wdata,
    input logic [NUM_SRC-1:0]     pend_q,
    input logic [NUM_SRC-1:0]     mask_q,
    input logic                   irq_out,
    input logic [VEC_W-1:0]       vec_out
);

    logic [NUM_SRC-1:0] req_flat;
    logic [NUM_SRC-1:0] act_d;
    logic [IDX_W-1:0]   vidx;
    logic [NUM_SRC-1:0] above;

    // Interleaved view of the request lines, from the ports
    always_comb begin
        for (int k = 0; k < N_PER_GROUP; k++) begin
            req_flat[2*k]   = ext_req[k];
            req_flat[2*k+1] = int_req[k];
        end
    end

    // Enabled pending word one cycle back
    always_ff @(posedge clk) begin
        if (!rst_n) act_d <= '0;
        else        act_d <= pend_q & mask_q;
    end

    assign vidx  = IDX_W'(vec_out >> SHIFT);
    assign above = (NUM_SRC'(1) << vidx) - NUM_SRC'(1);

    assert_pend_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> pend_q == $past(req_flat));

    assert_mask_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == 2'd1) |=> mask_q == $past(bus_wdata));

    assert_mask_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_wr && bus_addr == 2'd1) |=> $stable(mask_q));

    assert_irq_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> irq_out == |$past(pend_q & mask_q));

    assert_vec_winner_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (vec_out[SHIFT-1:0] == '0) && act_d[vidx] && ((act_d & above) == '0));

    assert_vec_none_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_out |-> vec_out == NONE_CODE);

endmodule

bind irq_prio_ctrl irq_ctrl_checker #(
    .N_PER_GROUP (N_PER_GROUP),
    .VEC_W       (VEC_W),
    .ENTRY_BYTES (ENTRY_BYTES),
    .NONE_CODE   (NONE_CODE)
) u_irq_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ext_req   (ext_req),
    .int_req   (int_req),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pend_q    (pend_vec),
    .mask_q    (mask_vec),
    .irq_out   (irq_out),
    .vec_out   (vec_out)
);

// File: tb/irq_prio_ctrl_bench.sv
`timescale 1ns/1ps
module irq_prio_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  ext_req = '0;
    logic [7:0]  int_req = '0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq_out;
    logic [7:0]  vec_out;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_prio_ctrl u_irq_prio_ctrl (
        .clk(clk), .rst_n(rst_n), .ext_req(ext_req), .int_req(int_req),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_out(irq_out), .vec_out(vec_out)
    );

    typedef struct packed {
        logic [7:0]  ext;
        logic [7:0]  intr;
        logic [15:0] mask;
        logic        irq;
        logic [7:0]  vec;
    } row_t;

    localparam int NROWS = 10;
    localparam row_t TBL [NROWS] = '{
        '{8'h01, 8'h00, 16'hFFFF, 1'b1, 8'h00},
        '{8'h00, 8'h01, 16'hFFFF, 1'b1, 8'h04},
        '{8'h80, 8'h80, 16'hFFFF, 1'b1, 8'h38},
        '{8'h00, 8'h80, 16'hFFFF, 1'b1, 8'h3C},
        '{8'hFF, 8'hFF, 16'h0000, 1'b0, 8'hFF},
        '{8'hFF, 8'hFF, 16'h8000, 1'b1, 8'h3C},
        '{8'h10, 8'h08, 16'hFFFF, 1'b1, 8'h1C},
        '{8'h10, 8'h08, 16'hFF7F, 1'b1, 8'h20},
        '{8'h00, 8'h00, 16'hFFFF, 1'b0, 8'hFF},
        '{8'h04, 8'h04, 16'h0020, 1'b1, 8'h14}
    };

    // Expected pending word from R1's bit placement
    function automatic logic [15:0] weave(input logic [7:0] e, input logic [7:0] i);
        logic [15:0] w;
        for (int k = 0; k < 8; k++) begin
            w[2*k]   = e[k];
            w[2*k+1] = i[k];
        end
        return w;
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [15:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            bad++; total++;
            $display("FAIL watchdog act=%0d exp=<20000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] rd;
        tick(); tick();
        // R3: state while reset is held
        check("R3 irq in reset", 16'(irq_out), 16'h0);
        check("R3 vec in reset", 16'(vec_out), 16'h00FF);
        rst_n = 1'b1;
        tick();
        bus_read(2'd1, rd); check("R3 mask after reset", rd, 16'h0000);
        bus_read(2'd0, rd); check("R2 pending idle", rd, 16'h0000);

        // Table walk: R1 R4 R5 R6 R7 R8
        for (int n = 0; n < NROWS; n++) begin
            ext_req = TBL[n].ext;
            int_req = TBL[n].intr;
            bus_write(2'd1, TBL[n].mask);      // edge A: pending and mask load
            bus_read(2'd1, rd); check("R4 mask readback", rd, TBL[n].mask);
            bus_read(2'd0, rd); check("R1 pending order", rd, weave(TBL[n].ext, TBL[n].intr));
            tick();                             // edge B: irq and vector
            check("R5 irq level", 16'(irq_out), 16'(TBL[n].irq));
            check("R6 R7 vector", 16'(vec_out), 16'(TBL[n].vec));
            bus_read(2'd2, rd); check("R8 vector read", rd, 16'(TBL[n].vec));
        end

        // R5 latency: pending moves first, irq one edge later
        ext_req = '0; int_req = '0;
        bus_write(2'd1, 16'h0008);
        tick();
        check("R7 idle irq", 16'(irq_out), 16'h0);
        int_req = 8'h02;                        // pending bit 3
        tick();
        bus_read(2'd0, rd); check("R2 pending one edge", rd, 16'h0008);
        check("R5 irq not yet", 16'(irq_out), 16'h0);
        tick();
        check("R5 irq next edge", 16'(irq_out), 16'h1);
        check("R6 vector bit3", 16'(vec_out), 16'h000C);

        // R2: writing pending address does not clear it
        bus_write(2'd0, 16'h0000);
        bus_read(2'd0, rd); check("R2 pending write ignored", rd, 16'h0008);
        tick();
        check("R2 irq held", 16'(irq_out), 16'h1);
        // R2: request dropped at source clears pending
        int_req = '0;
        tick(); tick();
        bus_read(2'd0, rd); check("R2 pending follows drop", rd, 16'h0000);
        check("R7 vector none", 16'(vec_out), 16'h00FF);

        // R9: reserved address and unselected bus
        bus_write(2'd3, 16'hFFFF);
        bus_read(2'd3, rd); check("R9 reserved reads zero", rd, 16'h0000);
        bus_read(2'd1, rd); check("R9 mask untouched", rd, 16'h0008);
        bus_sel = 1'b0; bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = 16'hAAAA;
        tick();
        bus_wr = 1'b0;
        check("R9 rdata unselected", bus_rdata, 16'h0000);
        bus_read(2'd1, rd); check("R9 unselected write", rd, 16'h0008);

        // R3: mid-run reset clears mask and outputs
        ext_req = 8'h01;
        bus_write(2'd1, 16'hFFFF);
        tick();
        check("R5 irq before reset", 16'(irq_out), 16'h1);
        rst_n = 1'b0;
        tick();
        check("R3 irq on reset", 16'(irq_out), 16'h0);
        check("R3 vec on reset", 16'(vec_out), 16'h00FF);
        rst_n = 1'b1;
        tick(); tick();
        bus_read(2'd1, rd); check("R3 mask cleared", rd, 16'h0000);
        check("R7 disabled pending", 16'(irq_out), 16'h0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule